// File: doc/BRIEF.md
# Capture Timer with Selectable Count Source

This block is a free-running up-counter with a compare register and two capture registers. A byte-wide mode register picks what advances the counter: synchronized rising edges of an external pin, or one of three one-cycle tick enables from an external prescaler. The mode register can also make the counter return to zero on the tick after it equals the compare value.

The capture logic copies the counter into capture register 0 or capture register 1 when edges arrive. Depending on the capture mode, those edges come from the external pin or from the output of a neighbouring timer. Separately, writing the mode register with its software-capture bit at 0 copies the counter into capture register 0 in that same cycle. An interrupt pulse of one cycle marks rising edges of the external pin whenever capture is enabled. This holds even when the neighbour's output is the capture source.

Both asynchronous inputs pass through a synchronizer before edge detection. Surrounding logic writes the mode and compare registers through simple write strobes. It reads the counter, both capture registers, the match flag and the interrupt pulse directly.

Top module: `cap_timer`

## Requirements
- R1: After reset: the counter, capture register 0 and capture register 1 are 0; the compare register is all ones, so the match flag is 0. The interrupt is 0, the count source is the external pin, clearing is off and capture mode is 00.
- R2: Mode bits [1:0] select the count source: 00 is synchronized external pin rising edges, 01 is `tickT1`, 10 is `tickT4`, 11 is `tickT16`. Each selected tick adds exactly 1 to the counter, and ticks on unselected sources leave it unchanged.
- R3: The match flag is 1 while the counter equals the compare register. With mode bit 2 (clear enable) at 1, a count tick during a match loads 0. With it at 0, the same tick increments.
- R4: With capture mode (bits [4:3]) 00, edges on either input change neither capture register and raise no interrupt.
- R5: In capture mode 01, a rising pin edge loads the counter into capture register 0 and gives a one-cycle interrupt pulse. A falling pin edge leaves capture register 1 unchanged.
- R6: In capture mode 10, a rising pin edge loads capture register 0 and pulses the interrupt. A falling pin edge loads capture register 1 and gives no interrupt.
- R7: In capture mode 11, rising and falling edges of `peerOut` load capture registers 0 and 1. Pin edges load neither register, and a rising pin edge still pulses the interrupt.
- R8: A mode write with bit 5 at 0 loads the current counter into capture register 0 at that clock edge, whatever the capture mode. A write with bit 5 at 1 leaves it unchanged.
- R9: When a hardware and a software capture of register 0 fall on the same edge, register 0 receives the counter value from before that edge, even if the counter also ticks on that edge.
- R10: Mode bits [7:6] are ignored. A write with them set takes effect exactly as the same write with them clear.
- R11: An input change driven between edges N and N+1 is seen as an edge during cycle N+2. The interrupt is high in cycle N+2 only, and capture and pin-count updates happen at edge N+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickT1 | input | 1 | Prescaler tick enable, fastest tap |
| tickT4 | input | 1 | Prescaler tick enable, middle tap |
| tickT16 | input | 1 | Prescaler tick enable, slowest tap |
| extPin | input | 1 | External capture/count pin (asynchronous) |
| peerOut | input | 1 | Neighbouring timer output (asynchronous) |
| modeWe | input | 1 | Mode register write strobe |
| modeWdata | input | 8 | Mode register write data |
| cmpWe | input | 1 | Compare register write strobe |
| cmpWdata | input | 16 | Compare register write data |
| count | output | 16 | Counter value |
| capReg0 | output | 16 | Capture register 0 |
| capReg1 | output | 16 | Capture register 1 |
| matchFlag | output | 1 | Counter equals compare register |
| intPulse | output | 1 | One-cycle capture interrupt |

## Verification
A hardware capture from a synchronized rising pin edge and a software capture from a mode write can both target capture register 0 on the same clock edge. The bench causes this by raising the pin and then issuing the mode write, with bit 5 at 0, exactly two cycles later, when the detected edge is live. It also drives a count tick in that cycle. The result is judged correct only if capture register 0 holds the counter value from before that edge while the counter itself has moved on by one.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int MODE_W   = 8;
  localparam int SEL_LSB  = 0;
  localparam int CLR_BIT  = 2;
  localparam int CAPM_LSB = 3;
  localparam int SWC_BIT  = 5;

  typedef enum logic [1:0] {
    SRC_PIN = 2'b00,
    SRC_T1  = 2'b01,
    SRC_T4  = 2'b10,
    SRC_T16 = 2'b11
  } cntSrc_e;

  typedef enum logic [1:0] {
    CAP_OFF       = 2'b00,
    CAP_PIN_RISE  = 2'b01,
    CAP_PIN_BOTH  = 2'b10,
    CAP_PEER_BOTH = 2'b11
  } capMode_e;

  typedef struct packed {
    logic countStep;
    logic clrEn;
    logic cap0Load;
    logic cap1Load;
  } tmrStrobe_t;
endpackage

// File: rtl/cap_timer_sync.sv
module cap_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  // pipe[LAST] is the synchronized sample, pipe[STAGES] the previous one
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[LAST] & ~pipe[STAGES];
  assign fall = ~pipe[LAST] & pipe[STAGES];

  // R11: a detected edge lasts one cycle only
  assert_edge_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);
endmodule

// File: rtl/cap_timer_ctrl.sv
module cap_timer_ctrl
  import cap_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickT1,
  input  logic              tickT4,
  input  logic              tickT16,
  input  logic              extPin,
  input  logic              peerOut,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWdata,
  output tmrStrobe_t        strb,
  output logic              intPulse
);
  localparam int N_SRC = 2;
  localparam int PIN_IDX = 0;
  localparam int PEER_IDX = 1;

  cntSrc_e    clkSel;
  capMode_e   capMode;
  logic       clrEnR;
  logic [N_SRC-1:0] rawIn;
  logic [N_SRC-1:0] rises;
  logic [N_SRC-1:0] falls;
  logic       swCap;
  logic       hwCap0;

  assign rawIn = {peerOut, extPin};

  for (genvar g = 0; g < N_SRC; g++) begin : gSync
    cap_timer_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[g]),
      .rise (rises[g]),
      .fall (falls[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel  <= SRC_PIN;
      capMode <= CAP_OFF;
      clrEnR  <= 1'b0;
    end else if (modeWe) begin
      clkSel  <= cntSrc_e'(modeWdata[SEL_LSB +: 2]);
      capMode <= capMode_e'(modeWdata[CAPM_LSB +: 2]);
      clrEnR  <= modeWdata[CLR_BIT];
    end
  end

  always_comb begin
    case (clkSel)
      SRC_PIN: strb.countStep = rises[PIN_IDX];
      SRC_T1:  strb.countStep = tickT1;
      SRC_T4:  strb.countStep = tickT4;
      default: strb.countStep = tickT16;
    endcase
  end

  always_comb begin
    case (capMode)
      CAP_PIN_RISE:  hwCap0 = rises[PIN_IDX];
      CAP_PIN_BOTH:  hwCap0 = rises[PIN_IDX];
      CAP_PEER_BOTH: hwCap0 = rises[PEER_IDX];
      default:       hwCap0 = 1'b0;
    endcase
    case (capMode)
      CAP_PIN_BOTH:  strb.cap1Load = falls[PIN_IDX];
      CAP_PEER_BOTH: strb.cap1Load = falls[PEER_IDX];
      default:       strb.cap1Load = 1'b0;
    endcase
  end

  assign swCap         = modeWe & ~modeWdata[SWC_BIT];
  assign strb.cap0Load = hwCap0 | swCap;
  assign strb.clrEn    = clrEnR;
  assign intPulse      = (capMode != CAP_OFF) & rises[PIN_IDX];

  // R5: the interrupt is a single-cycle pulse
  assert_int_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |=> !intPulse);

  // R8: a software capture write always requests a load of register 0
  assert_sw_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && !modeWdata[SWC_BIT]) |-> strb.cap0Load);

  // R10: reserved bits do not alter what the mode register keeps
  assert_rsvd_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeWe && modeWdata[7:6] != 2'b00) |=>
      {capMode, clrEnR, clkSel} == $past(modeWdata[4:0]));
endmodule

// File: rtl/cap_timer_dp.sv
module cap_timer_dp
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic             cmpWe,
  input  logic [CNT_W-1:0] cmpWdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capReg0,
  output logic [CNT_W-1:0] capReg1,
  output logic             matchFlag
);
  logic [CNT_W-1:0] cmpReg;

  assign matchFlag = (count == cmpReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cmpReg <= '1;
    else if (cmpWe) cmpReg <= cmpWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.countStep) begin
      if (strb.clrEn && matchFlag) count <= '0;
      else                         count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg0 <= '0;
      capReg1 <= '0;
    end else begin
      if (strb.cap0Load) capReg0 <= count;
      if (strb.cap1Load) capReg1 <= count;
    end
  end

  // R2: without a selected tick the counter holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.countStep |=> count == $past(count));

  // R3: a tick during a match with clearing on returns the counter to zero
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countStep && strb.clrEn && matchFlag) |=> count == '0);

  // R9: register 0 takes the pre-edge count whichever capture requested it
  assert_cap0_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.cap0Load |=> capReg0 == $past(count));

  // R6: register 1 takes the pre-edge count on its load
  assert_cap1_value_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.cap1Load |=> capReg1 == $past(count));
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickT1,
  input  logic             tickT4,
  input  logic             tickT16,
  input  logic             extPin,
  input  logic             peerOut,
  input  logic             modeWe,
  input  logic [7:0]       modeWdata,
  input  logic             cmpWe,
  input  logic [CNT_W-1:0] cmpWdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capReg0,
  output logic [CNT_W-1:0] capReg1,
  output logic             matchFlag,
  output logic             intPulse
);
  tmrStrobe_t strb;

  cap_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickT1    (tickT1),
    .tickT4    (tickT4),
    .tickT16   (tickT16),
    .extPin    (extPin),
    .peerOut   (peerOut),
    .modeWe    (modeWe),
    .modeWdata (modeWdata),
    .strb      (strb),
    .intPulse  (intPulse)
  );

  cap_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpWe     (cmpWe),
    .cmpWdata  (cmpWdata),
    .count     (count),
    .capReg0   (capReg0),
    .capReg1   (capReg1),
    .matchFlag (matchFlag)
  );
endmodule

// File: tb/sim_cap_timer.sv
module sim_cap_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickT1 = 0, tickT4 = 0, tickT16 = 0;
  logic extPin = 0, peerOut = 0;
  logic modeWe = 0;
  logic [7:0] modeWdata = '0;
  logic cmpWe = 0;
  logic [15:0] cmpWdata = '0;
  logic [15:0] count, capReg0, capReg1;
  logic matchFlag, intPulse;

  cap_timer u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    int          cyc;
    int          sel;   // 0 count, 1 cap0, 2 cap1, 3 match, 4 interrupt
    logic [15:0] val;
    string       tag;
  } expItem_t;

  expItem_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit monOn = 0;
  bit done = 0;
  logic [15:0] mcount = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] pick(int sel);
    case (sel)
      0: return count;
      1: return capReg0;
      2: return capReg1;
      3: return {15'd0, matchFlag};
      default: return {15'd0, intPulse};
    endcase
  endfunction

  // monitor: pops every expectation due in this cycle
  always @(negedge clk) begin
    if (monOn) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc == cyc) begin
          checks++;
          if (pick(sb[i].sel) !== sb[i].val) begin
            errors++;
            $display("FAIL %s: output %0d actual %h expected %h",
                     sb[i].tag, sb[i].sel, pick(sb[i].sel), sb[i].val);
          end
          sb.delete(i);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_at(string tag, int sel, logic [15:0] val, int dly);
    sb.push_back('{cyc + dly, sel, val, tag});
  endtask

  function automatic logic [7:0] md(bit swN, logic [1:0] cap, bit clr, logic [1:0] sel);
    return {2'b00, swN, cap, clr, sel};
  endfunction

  task automatic writeMode(logic [7:0] d);
    modeWe = 1; modeWdata = d;
    step();
    modeWe = 0;
  endtask

  task automatic writeCmp(logic [15:0] d);
    cmpWe = 1; cmpWdata = d;
    step();
    cmpWe = 0;
  endtask

  // which: 1 T1, 4 T4, 16 T16; counted says whether the model advances
  task automatic pulseTick(int which, bit counted, string tag);
    tickT1 = (which == 1); tickT4 = (which == 4); tickT16 = (which == 16);
    step();
    tickT1 = 0; tickT4 = 0; tickT16 = 0;
    if (counted) mcount++;
    expect_at(tag, 0, mcount, 0);
  endtask

  task automatic settle();
    repeat (4) step();
  endtask

  initial begin
    repeat (3) step();
    rstN = 1;
    monOn = 1;
    step();
    // R1 reset state
    expect_at("R1 count", 0, 16'h0, 0);
    expect_at("R1 cap0", 1, 16'h0, 0);
    expect_at("R1 cap1", 2, 16'h0, 0);
    expect_at("R1 match", 3, 16'h0, 0);
    expect_at("R1 int", 4, 16'h0, 0);
    step();

    // R2 pin source by default: prescaler ticks ignored
    pulseTick(1, 0, "R2 T1 ignored while pin selected");
    writeMode(md(1, 2'b00, 0, 2'b01));
    pulseTick(1, 1, "R2 T1 counts");
    pulseTick(4, 0, "R2 T4 ignored under T1");
    pulseTick(16, 0, "R2 T16 ignored under T1");
    writeMode(md(1, 2'b00, 0, 2'b10));
    pulseTick(4, 1, "R2 T4 counts");
    pulseTick(1, 0, "R2 T1 ignored under T4");
    writeMode(md(1, 2'b00, 0, 2'b11));
    pulseTick(16, 1, "R2 T16 counts");

    // R2/R11/R4: pin as count source, capture off
    writeMode(md(1, 2'b00, 0, 2'b00));
    extPin = 1;
    expect_at("R11 pin count not before N+3", 0, mcount, 2);
    expect_at("R2 pin rising edge counts at N+3", 0, mcount + 16'd1, 3);
    expect_at("R4 no interrupt with capture off", 4, 16'h0, 2);
    expect_at("R4 cap0 unchanged with capture off", 1, 16'h0, 3);
    mcount++;
    settle();
    extPin = 0;
    expect_at("R2 falling pin edge does not count", 0, mcount, 3);
    settle();

    // R3 clear on match
    writeMode(md(1, 2'b00, 1, 2'b01));
    writeCmp(mcount + 16'd2);
    pulseTick(1, 1, "R3 count toward compare");
    pulseTick(1, 1, "R3 reach compare");
    expect_at("R3 match flag high", 3, 16'h1, 0);
    tickT1 = 1; step(); tickT1 = 0;
    mcount = 0;
    expect_at("R3 cleared on tick at match", 0, 16'h0, 0);
    writeMode(md(1, 2'b00, 0, 2'b01));
    writeCmp(16'h0);
    expect_at("R3 match at zero", 3, 16'h1, 0);
    pulseTick(1, 1, "R3 no clear when disabled");
    expect_at("R3 match drops", 3, 16'h0, 0);
    pulseTick(1, 1, "R3 advance");

    // R5 mode 01
    writeMode(md(1, 2'b01, 0, 2'b01));
    extPin = 1;
    expect_at("R5/R11 interrupt at N+2", 4, 16'h1, 2);
    expect_at("R11 interrupt gone at N+3", 4, 16'h0, 3);
    expect_at("R5 cap0 on rising pin", 1, mcount, 3);
    settle();
    extPin = 0;
    expect_at("R5 falling pin leaves cap1", 2, 16'h0, 3);
    expect_at("R5 no interrupt on falling", 4, 16'h0, 2);
    settle();

    // R6 mode 10
    pulseTick(1, 1, "R6 advance");
    writeMode(md(1, 2'b10, 0, 2'b01));
    extPin = 1;
    expect_at("R6 interrupt on rising", 4, 16'h1, 2);
    expect_at("R6 cap0 on rising", 1, mcount, 3);
    settle();
    pulseTick(1, 1, "R6 advance");
    extPin = 0;
    expect_at("R6 no interrupt on falling", 4, 16'h0, 2);
    expect_at("R6 cap1 on falling", 2, mcount, 3);
    settle();

    // R7 mode 11
    pulseTick(1, 1, "R7 advance");
    writeMode(md(1, 2'b11, 0, 2'b01));
    peerOut = 1;
    expect_at("R7 no interrupt from peer", 4, 16'h0, 2);
    expect_at("R7 cap0 on peer rising", 1, mcount, 3);
    settle();
    pulseTick(1, 1, "R7 advance");
    peerOut = 0;
    expect_at("R7 cap1 on peer falling", 2, mcount, 3);
    settle();
    pulseTick(1, 1, "R7 advance");
    extPin = 1;
    expect_at("R7 interrupt on pin rising", 4, 16'h1, 2);
    expect_at("R7 pin rising does not capture", 1, mcount - 16'd2, 3);
    settle();
    extPin = 0;
    expect_at("R7 pin falling does not capture", 2, mcount - 16'd1, 3);
    settle();

    // R8 software capture
    pulseTick(1, 1, "R8 advance");
    modeWe = 1; modeWdata = md(0, 2'b11, 0, 2'b01);
    expect_at("R8 software capture", 1, mcount, 1);
    step(); modeWe = 0;
    pulseTick(1, 1, "R8 advance");
    writeMode(md(1, 2'b11, 0, 2'b01));
    expect_at("R8 bit set means no capture", 1, mcount - 16'd1, 0);

    // R10 reserved bits ignored
    writeMode(8'hC0 | md(1, 2'b01, 0, 2'b01));
    extPin = 1;
    expect_at("R10 mode with reserved bits interrupts", 4, 16'h1, 2);
    expect_at("R10 mode with reserved bits captures", 1, mcount, 3);
    settle();
    extPin = 0;
    settle();
    pulseTick(1, 1, "R10 source still T1");

    // R9 hardware and software capture on one edge, with a tick
    writeMode(md(1, 2'b01, 0, 2'b01));
    extPin = 1;
    expect_at("R9 interrupt", 4, 16'h1, 2);
    expect_at("R9 cap0 takes pre-edge count", 1, mcount, 3);
    expect_at("R9 counter still ticks", 0, mcount + 16'd1, 3);
    step(); step();
    modeWe = 1; modeWdata = md(0, 2'b01, 0, 2'b01); tickT1 = 1;
    step();
    modeWe = 0; tickT1 = 0;
    mcount++;
    settle();
    extPin = 0;
    settle();

    if (sb.size() != 0) begin
      errors += sb.size();
      $display("FAIL R1: %0d expectations never reached, actual %0d expected 0", sb.size(), sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule